// File: doc/BRIEF.md
# Accumulator Machine Fetch and Decode Sequencer

This block is the timing and control front end of a small accumulator machine built around one shared bus. A 4-bit sequence counter names the timing step of the current instruction. A named state machine follows the counter. The machine moves through ADDR (step 0), FETCH (step 1), DECODE (step 2) and RESOLVE (step 3). It then either returns to ADDR or enters EXEC (steps 4 and up). The block holds the program counter, the address register, the instruction register and the indirect flag. In each step it drives the bus source select, the load and increment strobes of those registers and the memory read strobe.

Instruction words carry the indirect flag in bit 15, a 3-bit opcode in bits 14..12 and a 12-bit address in bits 11..0. The opcode is decoded into eight one-hot lines. Line 7 marks a register or I/O instruction. For those, RESOLVE is the execute step, and the block itself sends the counter back to step 0. Lines 0 to 6 mark memory-reference instructions. For an indirect one, RESOLVE replaces the address register with the word read from memory. The counter then keeps counting through EXEC until the execute logic pulses `exec_done`.

The transitions are as follows. ADDR goes to FETCH, and FETCH goes to DECODE. DECODE goes to RESOLVE. RESOLVE goes to ADDR when line 7 is set, and to EXEC otherwise. EXEC goes to ADDR when the counter wraps from 15. `exec_done` sends any state to ADDR.

Top module: `cpu_fetch_seq`

## Requirements
- R1: While reset is held, the step is 0, PC is 0, AR is 0, the flag is 0 and the decode lines read 8'b0000_0001, so the first instruction is fetched from address 0.
- R2: In step 0, bus_sel is 3'b010 (PC source) and ar_ld is 1, with no other strobe; AR holds the old PC afterwards.
- R3: In step 1, mem_rd, ir_ld and pc_inr are 1 and bus_sel is 3'b111 (memory source); IR takes M[AR] and PC goes up by one.
- R4: In step 2, bus_sel is 3'b101 (IR source) and ar_ld is 1; AR takes IR bits 11..0 and the flag takes IR bit 15.
- R5: From step 2 on, d_lines has exactly one bit set, at index IR[14:12].
- R6: In step 3 with line 7 clear and the flag set, mem_rd and ar_ld are 1 and bus_sel is 3'b111; AR takes bits 11..0 of M[AR].
- R7: In step 3 with line 7 clear and the flag clear, no strobe is active, bus_sel is 3'b000 and AR holds; the next step is 4.
- R8: In step 3 with line 7 set, for either flag value, no strobe is active and the next step is 0.
- R9: exec_done during any step makes the next step 0 and takes priority over counting; the register strobes of that step still take effect.
- R10: Without a clear, steps 4 to 15 have no strobe and bus_sel 3'b000; the step rises by one each cycle and wraps from 15 to 0, which begins a new fetch.
- R11: mem_addr always shows AR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_done | input | 1 | Execute path finished; return to step 0 |
| mem_rdata | input | 16 | Memory word at mem_addr (combinational read) |
| mem_addr | output | 12 | Memory address, equal to AR |
| mem_rd | output | 1 | Memory read strobe |
| bus_sel | output | 3 | Common bus source select |
| ar_ld | output | 1 | AR load from bus |
| ir_ld | output | 1 | IR load from bus |
| pc_inr | output | 1 | PC increment |
| pc | output | 12 | Program counter |
| d_lines | output | 8 | One-hot opcode decode |
| i_flag | output | 1 | Indirect flag |
| t_state | output | 4 | Current timing step |

## Verification
The bench builds the block with its default parameters: 12-bit addresses, 16-bit words, a 3-bit opcode and a 4-bit counter. The 3-bit opcode lets a short program reach all eight decode lines, both flag values on line 7, and both direct and indirect memory references. The 4-bit counter lets a single unfinished instruction run through every EXEC step and wrap back to a fetch within sixteen cycles. A clear pulse is placed in steps 0, 1, 3, 4, 5 and 6 to show its priority and what survives it.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    localparam logic [2:0] BUS_NONE = 3'b000;
    localparam logic [2:0] BUS_PC   = 3'b010;
    localparam logic [2:0] BUS_IR   = 3'b101;
    localparam logic [2:0] BUS_MEM  = 3'b111;

    typedef enum logic [2:0] {
        PH_ADDR,
        PH_FETCH,
        PH_DECODE,
        PH_RESOLVE,
        PH_EXEC
    } phase_e;

    typedef struct packed {
        logic [2:0] bus_sel;
        logic       mem_rd;
        logic       ar_ld;
        logic       ir_ld;
        logic       pc_inr;
        logic       i_ld;
    } ctl_t;

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
    parameter int SC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [SC_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    // R9: a clear wins over counting
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
    parameter int OPC_W = 3,
    localparam int LINES = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [LINES-1:0] lines
);

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign lines[k] = (opcode == OPC_W'(k));
    end

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
    import cpu_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ar,
    output logic [WORD_W-1:0] ir,
    output logic              i_flag
);

    localparam int I_BIT = WORD_W - 1;

    logic [WORD_W-1:0] bus;

    always_comb begin
        unique case (ctl.bus_sel)
            BUS_PC:  bus = WORD_W'(pc);
            BUS_IR:  bus = ir;
            BUS_MEM: bus = mem_rdata;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc     <= '0;
            ar     <= '0;
            ir     <= '0;
            i_flag <= 1'b0;
        end else begin
            if (ctl.pc_inr) pc     <= pc + 1'b1;
            if (ctl.ar_ld)  ar     <= bus[ADDR_W-1:0];
            if (ctl.ir_ld)  ir     <= bus;
            if (ctl.i_ld)   i_flag <= ir[I_BIT];
        end
    end

    // R2: a load with the PC source copies the old PC into AR
    a_r2_ar_gets_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ar_ld && ctl.bus_sel == BUS_PC) |=> (ar == $past(pc)));

    // R3: an increment strobe advances PC by one
    a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inr |=> (pc == $past(pc) + 1'b1));

    // R4: the flag follows IR bit 15 after a flag load
    a_r4_flag_from_ir: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.i_ld |=> (i_flag == $past(ir[I_BIT])));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import cpu_seq_pkg::*;
#(
    parameter int SC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_done,
    input  logic            line7,
    input  logic            i_flag,
    input  logic [SC_W-1:0] sc,
    output ctl_t            ctl,
    output logic            sc_clr
);

    localparam logic [SC_W-1:0] SC_LAST = '1;

    phase_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_ADDR;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_ADDR:    state_nx = PH_FETCH;
            PH_FETCH:   state_nx = PH_DECODE;
            PH_DECODE:  state_nx = PH_RESOLVE;
            PH_RESOLVE: state_nx = line7 ? PH_ADDR : PH_EXEC;
            PH_EXEC:    state_nx = (sc == SC_LAST) ? PH_ADDR : PH_EXEC;
            default:    state_nx = PH_ADDR;
        endcase
        if (exec_done) begin
            state_nx = PH_ADDR;
        end
    end

    always_comb begin
        ctl    = '0;
        sc_clr = exec_done;
        unique case (state)
            PH_ADDR: begin
                ctl.bus_sel = BUS_PC;
                ctl.ar_ld   = 1'b1;
            end
            PH_FETCH: begin
                ctl.bus_sel = BUS_MEM;
                ctl.mem_rd  = 1'b1;
                ctl.ir_ld   = 1'b1;
                ctl.pc_inr  = 1'b1;
            end
            PH_DECODE: begin
                ctl.bus_sel = BUS_IR;
                ctl.ar_ld   = 1'b1;
                ctl.i_ld    = 1'b1;
            end
            PH_RESOLVE: begin
                if (line7) begin
                    sc_clr = 1'b1;
                end else if (i_flag) begin
                    ctl.bus_sel = BUS_MEM;
                    ctl.mem_rd  = 1'b1;
                    ctl.ar_ld   = 1'b1;
                end
            end
            PH_EXEC: begin
                ctl = '0;
            end
            default: begin
                ctl = '0;
            end
        endcase
    end

    // R10: the named state agrees with the counter at every step
    a_r10_state_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PH_ADDR)    == (sc == SC_W'(0))) &&
        ((state == PH_FETCH)   == (sc == SC_W'(1))) &&
        ((state == PH_DECODE)  == (sc == SC_W'(2))) &&
        ((state == PH_RESOLVE) == (sc == SC_W'(3))));

    // R7: a direct memory reference moves on from step 3 to step 4
    a_r7_direct_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RESOLVE && !line7 && !i_flag && !exec_done) |=> (sc == SC_W'(4)));

endmodule

// File: rtl/cpu_fetch_seq.sv
module cpu_fetch_seq
    import cpu_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 3,
    parameter int SC_W   = 4,
    localparam int WORD_W = ADDR_W + OPC_W + 1,
    localparam int LINES  = 1 << OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_done,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [2:0]        bus_sel,
    output logic              ar_ld,
    output logic              ir_ld,
    output logic              pc_inr,
    output logic [ADDR_W-1:0] pc,
    output logic [LINES-1:0]  d_lines,
    output logic              i_flag,
    output logic [SC_W-1:0]   t_state
);

    ctl_t              ctl;
    logic              sc_clr;
    logic [ADDR_W-1:0] ar;
    logic [WORD_W-1:0] ir;

    seq_counter #(.SC_W(SC_W)) u_sc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sc_clr),
        .count (t_state)
    );

    seq_ctrl #(.SC_W(SC_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_done (exec_done),
        .line7     (d_lines[LINES-1]),
        .i_flag    (i_flag),
        .sc        (t_state),
        .ctl       (ctl),
        .sc_clr    (sc_clr)
    );

    fetch_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ar        (ar),
        .ir        (ir),
        .i_flag    (i_flag)
    );

    op_decoder #(.OPC_W(OPC_W)) u_dec (
        .opcode (ir[WORD_W-2 -: OPC_W]),
        .lines  (d_lines)
    );

    assign mem_addr = ar;
    assign mem_rd   = ctl.mem_rd;
    assign bus_sel  = ctl.bus_sel;
    assign ar_ld    = ctl.ar_ld;
    assign ir_ld    = ctl.ir_ld;
    assign pc_inr   = ctl.pc_inr;

    // R5: the decode output is always one-hot
    a_r5_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(d_lines) == 1);

    // R8: a line-7 instruction returns to step 0 after step 3
    a_r8_line7_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (t_state == SC_W'(3) && d_lines[LINES-1]) |=> (t_state == '0));

    // R9: the completion pulse restarts the fetch
    a_r9_done_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> (t_state == '0 && bus_sel == BUS_PC && ar_ld));

    // R10: execute steps leave every strobe low
    a_r10_exec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (t_state > SC_W'(3)) |-> (!mem_rd && !ar_ld && !ir_ld && !pc_inr && bus_sel == BUS_NONE));

endmodule

// File: tb/cpu_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_fetch_seq_tb_top;

    localparam int MEM_N = 256;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exec_done;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [2:0]  bus_sel;
    logic        ar_ld, ir_ld, pc_inr;
    logic [11:0] pc;
    logic [7:0]  d_lines;
    logic        i_flag;
    logic [3:0]  t_state;

    always #4 clk = ~clk;

    logic [15:0] mem [MEM_N];
    assign mem_rdata = mem[mem_addr[7:0]];

    cpu_fetch_seq dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_done (exec_done),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .bus_sel   (bus_sel),
        .ar_ld     (ar_ld),
        .ir_ld     (ir_ld),
        .pc_inr    (pc_inr),
        .pc        (pc),
        .d_lines   (d_lines),
        .i_flag    (i_flag),
        .t_state   (t_state)
    );

    typedef struct {
        logic [3:0]  t;
        logic [2:0]  sel;
        logic        rd, arl, irl, inr;
        logic [11:0] addr, pcv;
        logic        chk_d, chk_i;
        logic [7:0]  d;
        logic        i;
    } exp_t;

    exp_t sbq[$];
    int n_chk = 0;
    int n_err = 0;

    logic [3:0]  m_t  = '0;
    logic [11:0] m_pc = '0;
    logic [11:0] m_ar = '0;
    logic [15:0] m_ir = '0;
    logic        m_i  = 1'b0;

    function automatic logic [15:0] mk(input logic ind, input int op, input logic [11:0] a);
        return {ind, 3'(op), a};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // driver: one cycle of stimulus plus the expected outputs of that cycle
    task automatic step(input bit done);
        exp_t e;
        logic l7;
        l7 = (m_ir[14:12] == 3'd7);
        e.t = m_t; e.addr = m_ar; e.pcv = m_pc;
        e.sel = 3'b000; e.rd = 0; e.arl = 0; e.irl = 0; e.inr = 0;
        case (m_t)
            4'd0: begin e.sel = 3'b010; e.arl = 1; end
            4'd1: begin e.sel = 3'b111; e.rd = 1; e.irl = 1; e.inr = 1; end
            4'd2: begin e.sel = 3'b101; e.arl = 1; end
            4'd3: if (!l7 && m_i) begin e.sel = 3'b111; e.rd = 1; e.arl = 1; end
            default: ;
        endcase
        e.chk_d = (m_t >= 4'd2);
        e.d     = 8'b1 << m_ir[14:12];
        e.chk_i = (m_t >= 4'd3);
        e.i     = m_i;
        exec_done = done;
        sbq.push_back(e);
        case (m_t)
            4'd0: m_ar = m_pc;
            4'd1: begin m_ir = mem[m_ar[7:0]]; m_pc = m_pc + 1'b1; end
            4'd2: begin m_ar = m_ir[11:0]; m_i = m_ir[15]; end
            4'd3: if (!l7 && m_i) m_ar = mem[m_ar[7:0]][11:0];
            default: ;
        endcase
        if (done || (m_t == 4'd3 && l7)) m_t = '0;
        else m_t = m_t + 1'b1;
        @(negedge clk);
    endtask

    task automatic run_instr(input int done_at);
        do begin
            step(int'(m_t) == done_at);
        end while (m_t != '0);
    endtask

    // monitor: pop and compare one expected cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sbq.size() > 0) begin
                exp_t e;
                string tg;
                e = sbq.pop_front();
                case (e.t)
                    4'd0: tg = "R2";
                    4'd1: tg = "R3";
                    4'd2: tg = "R4";
                    4'd3: tg = "R6 R7 R8";
                    default: tg = "R10";
                endcase
                chk(t_state == e.t, {"R9 R10 step ", tg}, t_state, e.t);
                chk(bus_sel == e.sel && mem_rd == e.rd && ar_ld == e.arl &&
                    ir_ld == e.irl && pc_inr == e.inr,
                    {"strobes ", tg}, {bus_sel, mem_rd, ar_ld, ir_ld, pc_inr},
                    {e.sel, e.rd, e.arl, e.irl, e.inr});
                chk(mem_addr == e.addr, {"R11 AR ", tg}, mem_addr, e.addr);
                chk(pc == e.pcv, "R3 PC", pc, e.pcv);
                if (e.chk_d) chk(d_lines == e.d, "R5 decode", d_lines, e.d);
                if (e.chk_i) chk(i_flag == e.i, "R4 flag", i_flag, e.i);
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < MEM_N; a++) mem[a] = '0;
        mem[0]     = mk(0, 7, 12'h001);
        mem[1]     = mk(1, 7, 12'h040);
        mem[2]     = mk(0, 2, 12'h030);
        mem[3]     = mk(1, 0, 12'h031);
        mem[8'h31] = 16'h80A5;
        mem[4]     = mk(0, 5, 12'h032);
        mem[5]     = mk(1, 6, 12'h033);
        mem[8'h33] = 16'hF123;
        mem[6]     = mk(0, 1, 12'h0FF);
        mem[7]     = mk(0, 3, 12'h034);
        mem[8]     = mk(1, 4, 12'h035);
        mem[8'h35] = 16'h0FFF;
        mem[9]     = mk(0, 7, 12'h800);
        mem[10]    = mk(0, 2, 12'h036);

        exec_done = 1'b0;
        rst_n     = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset values
        chk(t_state == 4'd0, "R1 step", t_state, 0);
        chk(pc == 12'd0, "R1 PC", pc, 0);
        chk(mem_addr == 12'd0, "R1 AR", mem_addr, 0);
        chk(d_lines == 8'b0000_0001, "R1 decode", d_lines, 1);
        chk(i_flag == 1'b0, "R1 flag", i_flag, 0);
        rst_n = 1'b1;

        run_instr(-1);   // R8 register form
        run_instr(-1);   // R8 I/O form
        run_instr(4);    // R7 direct, done at step 4
        run_instr(5);    // R6 indirect, done at step 5
        run_instr(6);    // R7 direct, done at step 6
        run_instr(3);    // R6 R9 indirect with done in step 3
        run_instr(1);    // R9 done during fetch
        run_instr(-1);   // R10 wrap from step 15
        run_instr(4);    // R6 indirect to all-ones address
        run_instr(-1);   // R8 line 7 with address bits set
        run_instr(0);    // R9 done in step 0
        run_instr(4);    // refetch of the same word
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule